// File: doc/BRIEF.md
# ISDN B-Channel Time-Slot Port

This block moves one 8-bit B-channel byte per frame between a parallel interface and a serial time-slot bus with two B-channel slots. Each frame it loads one transmit byte and drives it onto the bus inside the selected slot. It also captures one byte from the same slot and reports it with a one-cycle valid strobe. Outside the selected slot the transmit pin is released, so other devices can share the bus.

Two framing formats are supported. In the half-rate format each bit lasts two data clocks, and B2 starts 16 clocks after B1. In the single-pulse format bits run at the data-clock rate, transmit moves on rising edges and receive samples on falling edges, with the slots starting at fixed edge counts after the sync. A static format pin is accepted only after it has held the same level at two consecutive sync edges. A channel-select pin is latched at every frame start and applies to both directions.

The bus signals (data clock, sync, format pin, channel pin, receive data) are sampled by a fast system clock and resynchronised. All bus timing is derived from detected edges of the data clock.

Top module: `isdn_bslot_port`

## Requirements
- R1: `fmt_sel_i` = 0 selects the half-rate format and 1 selects the single-pulse format. A new level is adopted at the second consecutive sync rising edge at which it is seen. A level present at only one sync edge leaves the format unchanged.
- R2: `chan_sel_i` = 0 selects slot B1 and 1 selects slot B2 for both transmit and receive. It is latched at the frame start, and a change during a frame has no effect until the next frame start.
- R3: In the half-rate format, the frame starts at the data-clock rising edge where sync is first seen high (clock 0). Bit k of the byte (k = 0 is the MSB) is driven for clocks base+2k and base+2k+1, with base 0 for B1 and 16 for B2. The output changes only on rising edges.
- R4: In the half-rate format, `tx_oe_o` is low from clock base+16 on, for the whole unselected slot, and before the first frame start.
- R5: In the half-rate format, receive bit k is sampled once, at the rising edge of clock base+2k+1.
- R6: In the single-pulse format, the frame starts at the falling edge where sync is first seen high. Bit k is driven from the (base+k)-th rising edge after it, with base 1 for B1 and 11 for B2. `tx_oe_o` is high for exactly those 8 clocks.
- R7: In the single-pulse format, receive bit k is sampled at the (base+k)-th falling edge after the frame start, MSB first.
- R8: After the last bit of the selected slot, `rx_byte_o` takes the received byte and `rx_valid_o` pulses for one system clock, once per frame. Data in the unselected slot is ignored.
- R9: The transmit byte is taken from `tx_byte_i` at the frame start. Later changes within the frame do not alter the bits sent.
- R10: After reset `tx_oe_o`, `tx_o`, `rx_valid_o` and `rx_byte_o` are 0, the format is half-rate and the channel is B1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Bus data clock (asynchronous) |
| sync_i | input | 1 | Frame sync (asynchronous) |
| fmt_sel_i | input | 1 | Format pin: 0 half-rate, 1 single-pulse |
| chan_sel_i | input | 1 | Slot select: 0 B1, 1 B2 |
| rx_pin_i | input | 1 | Serial receive data |
| tx_byte_i | input | DATA_BITS | Byte to send in the next frame |
| tx_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit drive enable (low = high impedance) |
| rx_byte_o | output | DATA_BITS | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_byte_o` updates |

## Verification
The assertions assume that every data-clock phase lasts at least three system clocks, so that each bus edge is seen as one isolated event. They also assume that sync and receive data change only together with a data-clock rising edge, and that the format and channel pins are quasi-static. The bench drives six system clocks per phase. It changes sync, receive data and the select pins only at the moment it raises the data clock, and it holds sync high for exactly one data-clock period per frame. The unselected slot is filled with the complement of the expected byte, so a slot mix-up shows up in the received value.

// File: rtl/isdn_bslot_pkg.sv
package isdn_bslot_pkg;
  typedef enum logic {
    FMT_HALF   = 1'b0,
    FMT_SINGLE = 1'b1
  } frame_fmt_e;
endpackage

// File: rtl/isdn_pin_sync.sv
module isdn_pin_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], pin_i[g]};
      end
      assign lvl_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/isdn_fmt_vote.sv
module isdn_fmt_vote
  import isdn_bslot_pkg::*;
#(
  parameter int         CONFIRM  = 2,
  parameter frame_fmt_e INIT_FMT = FMT_HALF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_i,
  input  logic       pin_i,
  output frame_fmt_e fmt_o,
  output frame_fmt_e fmt_nx_o
);
  localparam int CNT_W = $clog2(CONFIRM + 1);

  frame_fmt_e cand_q, cand_n, fmt_q, fmt_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cand_n = cand_q;
    cnt_n  = cnt_q;
    fmt_n  = fmt_q;
    if (sample_i) begin
      if (frame_fmt_e'(pin_i) != cand_q) begin
        cand_n = frame_fmt_e'(pin_i);
        cnt_n  = CNT_W'(1);
      end else if (cnt_q < CNT_W'(CONFIRM)) begin
        cnt_n = cnt_q + 1'b1;
      end
      if (cnt_n >= CNT_W'(CONFIRM) && cand_n != fmt_q) fmt_n = cand_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= INIT_FMT;
      cnt_q  <= CNT_W'(CONFIRM);
      fmt_q  <= INIT_FMT;
    end else begin
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
      fmt_q  <= fmt_n;
    end
  end

  assign fmt_o    = fmt_q;
  assign fmt_nx_o = fmt_n;
endmodule

// File: rtl/isdn_slot_timer.sv
module isdn_slot_timer
  import isdn_bslot_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int B1_START_SP = 1,
  parameter int B2_START_SP = 11,
  parameter int BIT_W       = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_fmt_e       fmt_i,
  input  logic             chan_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sync_i,
  output logic             mark_o,
  output logic             chan_q_o,
  output logic             tx_upd_o,
  output logic             tx_en_o,
  output logic [BIT_W-1:0] tx_bit_o,
  output logic             rx_take_o,
  output logic [BIT_W-1:0] rx_bit_o
);
  localparam int HALF_SPAN = 2 * DATA_BITS;
  localparam int LAST_IDX  = 2 * HALF_SPAN;
  localparam int IDX_W     = $clog2(LAST_IDX + 2);

  logic [IDX_W-1:0] ridx, fidx, r_now, f_now, base, r_off, f_off;
  logic sync_at_rise, sync_at_fall, chan_q, chan_now, mark;
  frame_fmt_e frm_fmt, fmt_now;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_comb begin
    if (fmt_i == FMT_HALF) mark = rise_i & sync_i & ~sync_at_rise;
    else                   mark = fall_i & sync_i & ~sync_at_fall;
    fmt_now  = mark ? fmt_i : frm_fmt;
    chan_now = mark ? chan_i : chan_q;
    r_now    = (mark && fmt_i == FMT_HALF) ? '0 : bump(ridx);
    f_now    = bump(fidx);
    if (fmt_now == FMT_HALF) base = chan_now ? IDX_W'(HALF_SPAN) : '0;
    else base = chan_now ? IDX_W'(B2_START_SP) : IDX_W'(B1_START_SP);
    r_off = r_now - base;
    f_off = f_now - base;
    if (fmt_now == FMT_HALF) begin
      tx_en_o   = (r_now >= base) && (r_off < IDX_W'(HALF_SPAN));
      tx_bit_o  = r_off[BIT_W:1];
      rx_take_o = rise_i & tx_en_o & r_off[0];
      rx_bit_o  = r_off[BIT_W:1];
    end else begin
      tx_en_o   = (r_now >= base) && (r_off < IDX_W'(DATA_BITS));
      tx_bit_o  = r_off[BIT_W-1:0];
      rx_take_o = fall_i & ~mark & (f_now >= base) && (f_off < IDX_W'(DATA_BITS));
      rx_bit_o  = f_off[BIT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ridx         <= '1;
      fidx         <= '1;
      sync_at_rise <= 1'b0;
      sync_at_fall <= 1'b0;
      frm_fmt      <= FMT_HALF;
      chan_q       <= 1'b0;
    end else begin
      if (rise_i) sync_at_rise <= sync_i;
      if (fall_i) sync_at_fall <= sync_i;
      if (mark) begin
        frm_fmt <= fmt_i;
        chan_q  <= chan_i;
        ridx    <= '0;
        fidx    <= '0;
      end else begin
        if (rise_i) ridx <= bump(ridx);
        if (fall_i) fidx <= bump(fidx);
      end
    end
  end

  assign mark_o   = mark;
  assign chan_q_o = chan_q;
  assign tx_upd_o = rise_i;
endmodule

// File: rtl/isdn_lane.sv
module isdn_lane #(
  parameter int DATA_BITS = 8,
  parameter int BIT_W     = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] tx_byte_i,
  input  logic                 tx_upd_i,
  input  logic                 tx_en_i,
  input  logic [BIT_W-1:0]     tx_bit_i,
  input  logic                 rx_take_i,
  input  logic [BIT_W-1:0]     rx_bit_i,
  input  logic                 rx_pin_i,
  output logic                 tx_o,
  output logic                 tx_oe_o,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] hold, src, rx_sh, rx_next;
  logic tx_pick;

  always_comb begin
    src     = load_i ? tx_byte_i : hold;
    tx_pick = src[TOP_BIT - tx_bit_i];
    rx_next = rx_sh;
    rx_next[TOP_BIT - rx_bit_i] = rx_pin_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      rx_sh      <= '0;
      tx_o       <= 1'b0;
      tx_oe_o    <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (load_i) hold <= tx_byte_i;
      if (tx_upd_i) begin
        tx_oe_o <= tx_en_i;
        tx_o    <= tx_en_i & tx_pick;
      end
      if (rx_take_i) begin
        rx_sh <= rx_next;
        if (rx_bit_i == TOP_BIT) begin
          rx_byte_o  <= rx_next;
          rx_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isdn_bslot_port.sv
module isdn_bslot_port
  import isdn_bslot_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2,
  parameter int B1_START_SP = 1,
  parameter int B2_START_SP = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dclk_i,
  input  logic                 sync_i,
  input  logic                 fmt_sel_i,
  input  logic                 chan_sel_i,
  input  logic                 rx_pin_i,
  input  logic [DATA_BITS-1:0] tx_byte_i,
  output logic                 tx_o,
  output logic                 tx_oe_o,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o
);
  localparam int BIT_W = $clog2(DATA_BITS);

  logic [4:0] pins_s;
  logic dclk_s, sync_s, fmt_s, chan_s, rx_s;
  logic dclk_d, sync_d;
  logic dclk_rise, dclk_fall, sync_rise;
  logic frame_mark, chan_q, tx_upd, tx_en, rx_take;
  logic [BIT_W-1:0] tx_bit, rx_bit;
  frame_fmt_e fmt_q, fmt_nx;

  isdn_pin_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({rx_pin_i, chan_sel_i, fmt_sel_i, sync_i, dclk_i}),
    .lvl_o(pins_s)
  );
  assign {rx_s, chan_s, fmt_s, sync_s, dclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_d <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      dclk_d <= dclk_s;
      sync_d <= sync_s;
    end
  end
  assign dclk_rise = dclk_s & ~dclk_d;
  assign dclk_fall = ~dclk_s & dclk_d;
  assign sync_rise = sync_s & ~sync_d;

  isdn_fmt_vote #(.CONFIRM(CONFIRM), .INIT_FMT(FMT_HALF)) u_vote (
    .clk(clk), .rst(rst), .sample_i(sync_rise), .pin_i(fmt_s),
    .fmt_o(fmt_q), .fmt_nx_o(fmt_nx)
  );

  isdn_slot_timer #(
    .DATA_BITS(DATA_BITS), .B1_START_SP(B1_START_SP),
    .B2_START_SP(B2_START_SP), .BIT_W(BIT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .fmt_i(fmt_nx), .chan_i(chan_s),
    .rise_i(dclk_rise), .fall_i(dclk_fall), .sync_i(sync_s),
    .mark_o(frame_mark), .chan_q_o(chan_q),
    .tx_upd_o(tx_upd), .tx_en_o(tx_en), .tx_bit_o(tx_bit),
    .rx_take_o(rx_take), .rx_bit_o(rx_bit)
  );

  isdn_lane #(.DATA_BITS(DATA_BITS), .BIT_W(BIT_W)) u_lane (
    .clk(clk), .rst(rst), .load_i(frame_mark), .tx_byte_i(tx_byte_i),
    .tx_upd_i(tx_upd), .tx_en_i(tx_en), .tx_bit_i(tx_bit),
    .rx_take_i(rx_take), .rx_bit_i(rx_bit), .rx_pin_i(rx_s),
    .tx_o(tx_o), .tx_oe_o(tx_oe_o), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o)
  );
endmodule

// File: rtl/isdn_bslot_port_chk.sv
module isdn_bslot_port_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sync_rise,
  input logic                 fmt_q,
  input logic                 chan_q,
  input logic                 frame_mark,
  input logic                 dclk_rise,
  input logic                 tx_o,
  input logic                 tx_oe_o,
  input logic [DATA_BITS-1:0] rx_byte_o,
  input logic                 rx_valid_o
);
  AST_FMT_AT_SYNC_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_q) |-> $past(sync_rise)); // R1
  AST_CHAN_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_q) |-> $past(frame_mark)); // R2
  AST_TX_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_oe_o) || !$stable(tx_o)) |-> $past(dclk_rise)); // R3
  AST_RELEASED_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    !tx_oe_o |-> !tx_o); // R4
  AST_RX_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R8
  AST_RX_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte_o) |-> rx_valid_o); // R8
endmodule

bind isdn_bslot_port isdn_bslot_port_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .sync_rise(sync_rise), .fmt_q(fmt_q),
  .chan_q(chan_q), .frame_mark(frame_mark), .dclk_rise(dclk_rise),
  .tx_o(tx_o), .tx_oe_o(tx_oe_o), .rx_byte_o(rx_byte_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/test_isdn_bslot_port.sv
`timescale 1ns/1ps
module test_isdn_bslot_port;
  localparam int HALF = 6;
  localparam int NCLK = 36;
  localparam int NVEC = 8;
  // {fmt, chan, tx byte, rx byte}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h81, 8'hC3},
    {1'b1, 1'b0, 8'h5A, 8'h96},
    {1'b1, 1'b1, 8'hFF, 8'h01},
    {1'b1, 1'b0, 8'h00, 8'hFE},
    {1'b0, 1'b1, 8'h7E, 8'h80},
    {1'b0, 1'b0, 8'h01, 8'h7F},
    {1'b1, 1'b1, 8'hC6, 8'h29}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic dclk = 1'b0, sync_p = 1'b0, fmt_p = 1'b0, chan_p = 1'b0, rx_p = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_o, tx_oe_o, rx_valid_o;
  logic [7:0] rx_byte_o;
  int n_chk = 0, n_fail = 0, vcnt = 0;

  always #4 clk = ~clk;

  isdn_bslot_port i_isdn_bslot_port (
    .clk(clk), .rst(rst), .dclk_i(dclk), .sync_i(sync_p), .fmt_sel_i(fmt_p),
    .chan_sel_i(chan_p), .rx_pin_i(rx_p), .tx_byte_i(tx_byte),
    .tx_o(tx_o), .tx_oe_o(tx_oe_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) if (rx_valid_o) vcnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // One frame; exp_fmt 0 half-rate, 1 single-pulse. flip_cyc >= 0 toggles
  // channel pin and transmit byte in that clock.
  task automatic run_frame(input bit exp_fmt, input bit exp_chan,
                           input logic [7:0] exp_tx, input logic [7:0] rx_send,
                           input int flip_cyc, input string req);
    int bad = 0, bad_act = 0, bad_exp = 0;
    int base  = exp_fmt ? (exp_chan ? 11 : 1) : (exp_chan ? 16 : 0);
    int obase = exp_fmt ? (exp_chan ? 1 : 11) : (exp_chan ? 0 : 16);
    int span  = exp_fmt ? 8 : 16;
    vcnt = 0;
    for (int c = 0; c < NCLK; c++) begin
      int e_oe, e_d, k;
      sync_p = (c == 0);
      if (c == flip_cyc) begin
        chan_p  = ~chan_p;
        tx_byte = ~tx_byte;
      end
      if (c >= base && c < base + span) begin
        k = exp_fmt ? c - base : (c - base) >> 1;
        rx_p = rx_send[7-k];
      end else if (c >= obase && c < obase + span) begin
        k = exp_fmt ? c - obase : (c - obase) >> 1;
        rx_p = ~rx_send[7-k];
      end else rx_p = c[0];
      dclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      e_oe = (c >= base && c < base + span) ? 1 : 0;
      e_d  = 0;
      if (e_oe == 1) begin
        k = exp_fmt ? c - base : (c - base) >> 1;
        e_d = int'(exp_tx[7-k]);
      end
      if ((int'(tx_oe_o) != e_oe || int'(tx_o) != e_d) && bad == 0) begin
        bad_act = c * 256 + int'(tx_oe_o) * 16 + int'(tx_o);
        bad_exp = c * 256 + e_oe * 16 + e_d;
      end
      if (int'(tx_oe_o) != e_oe || int'(tx_o) != e_d) bad++;
      @(negedge clk);
      dclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    chk(bad == 0, req, "tx clk*256+oe*16+data", bad_act, bad_exp);
    chk(rx_byte_o == rx_send, req, "rx byte", int'(rx_byte_o), int'(rx_send));
    chk(vcnt == 1, "R8", "rx_valid pulses per frame", vcnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit prev_fmt;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(tx_oe_o == 1'b0 && tx_o == 1'b0, "R10", "tx after reset", int'(tx_oe_o), 0);
    chk(rx_byte_o == 8'h00 && rx_valid_o == 1'b0, "R10", "rx after reset", int'(rx_byte_o), 0);
    // R4: clocks without sync never drive the bus
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        dclk = 1'b1; repeat (HALF) @(negedge clk); seen += int'(tx_oe_o);
        dclk = 1'b0; repeat (HALF) @(negedge clk); seen += int'(tx_oe_o);
      end
      chk(seen == 0, "R4", "oe before any frame", seen, 0);
    end

    // Vector table: R1 (change after 2 syncs), R2, R3, R5, R6, R7, R8
    prev_fmt = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      fmt_p   = VEC[v][17];
      chan_p  = VEC[v][16];
      tx_byte = VEC[v][15:8];
      repeat (4) @(negedge clk);
      run_frame(prev_fmt, VEC[v][16], VEC[v][15:8], VEC[v][7:0], -1,
                VEC[v][17] != prev_fmt ? "R1" : (VEC[v][17] ? "R6_R7" : "R3_R5"));
      run_frame(VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0], -1,
                VEC[v][17] ? "R6_R7" : "R3_R4_R5");
      prev_fmt = VEC[v][17];
    end

    // R1: one-frame excursion of the format pin is ignored (format stays single)
    fmt_p = 1'b0; chan_p = 1'b0; tx_byte = 8'h3B;
    repeat (4) @(negedge clk);
    run_frame(1'b1, 1'b0, 8'h3B, 8'hD2, -1, "R1");
    fmt_p = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(1'b1, 1'b0, 8'h3B, 8'h4D, -1, "R1");

    // R2, R9: mid-frame change of channel pin and tx byte has no effect
    tx_byte = 8'h96;
    repeat (4) @(negedge clk);
    run_frame(1'b1, 1'b0, 8'h96, 8'hB1, 4, "R2_R9");
    // R2: the flipped channel pin (B2) applies from the next frame
    run_frame(1'b1, 1'b1, 8'h69, 8'h5E, -1, "R2");

    // R2, R9 in half-rate format
    fmt_p = 1'b0; chan_p = 1'b1; tx_byte = 8'hE4;
    repeat (4) @(negedge clk);
    run_frame(1'b1, 1'b1, 8'hE4, 8'h17, -1, "R1");
    run_frame(1'b0, 1'b1, 8'hE4, 8'h17, -1, "R3_R4");
    run_frame(1'b0, 1'b1, 8'hE4, 8'hA8, 20, "R2_R9");
    finish_run();
  end
endmodule